// File: doc/BRIEF.md
# Oversampled Serial Receiver with Multi-Drop Sleep Filter

This block recovers characters from an asynchronous serial line. A mode word selects the character length (7, 8 or 9 bits), whether a parity bit follows and which sense it has, and whether one or two stop bits close the frame. Each bit is timed with a one-cycle enable that pulses sixteen times per bit period. Baud-rate generation is outside the block and supplies that enable.

Two separate inversions are available. One complements the raw line before anything else sees it. The other complements only the data bits after they are sampled. With the second, start, parity and stop levels are still judged on the line as received, and parity is judged on the restored data.

A sleep setting supports a bus where one master talks to several slaves. While asleep, the receiver passes on only characters whose top data bit is 1, which are address characters. It silently drops all others. Each accepted character appears with a one-cycle valid strobe and its parity and framing flags.

Top module: `uart_sleep_rx`

## Requirements
- R1: After reset, rx_valid, rx_data, parity_err and frame_err are all 0, and the receiver waits for a start bit.
- R2: mode[2:0] sets the character length: 3'b100 means 7 bits, 3'b101 means 8 and 3'b110 means 9. Bits arrive LSB first. rx_data holds the character right-aligned, and its unused upper bits read 0.
- R3: mode[6]=1 adds a parity bit after the data bits. mode[5] selects odd (0) or even (1). Even means the data ones plus the parity bit give an even total. A mismatch sets parity_err. With mode[6]=0 there is no parity bit and parity_err stays 0.
- R4: mode[4] selects one (0) or two (1) stop bits. Every expected stop bit is sampled, and any stop bit sampled at 0 sets frame_err.
- R5: line_inv=1 complements the whole rxd input before edge detection and sampling, so an idle line is then low.
- R6: data_inv=1 complements only the data bits of the delivered character. Parity is checked on the restored character.
- R7: With mode[7]=1, a character whose most significant data bit is 0 produces no rx_valid, whatever its errors. A character with that bit at 1 is delivered normally.
- R8: Each delivered character gives exactly one rx_valid pulse of one cycle. rx_data and both flags are nonzero only during that pulse.
- R9: A low level shorter than half a bit period is rejected as a false start and produces no character.
- R10: A new start bit may follow the final stop bit with no idle time, and both characters are received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit |
| rxd | input | 1 | Serial line |
| mode | input | 8 | Length [2:0], stop count [4], parity sense [5], parity enable [6], sleep [7]; bit 3 unused |
| line_inv | input | 1 | Complement the whole input line |
| data_inv | input | 1 | Complement the received data bits |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| parity_err | output | 1 | Parity mismatch, valid with rx_valid |
| frame_err | output | 1 | A stop bit was low, valid with rx_valid |

## Verification
A wrong bit counter or oversample count shows up within the same character. The character comes out shifted or its length is wrong, or the stop sample lands on a data bit and raises frame_err. A state machine that leaves its stop phase too early or too late shows up on the next character. Back-to-back frames lose or corrupt that following character. Faults in the sleep filter or in either inversion appear as a missing or unexpected strobe, or as complemented data, in the very first character of the affected setting. The bench therefore sweeps every combination of mode, inversion and sleep setting.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_MAX = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_even;
        logic       two_stop;
        logic       sleep;
        logic       data_inv;
    } rx_cfg_t;

    function automatic logic [3:0] decode_len(input logic [2:0] code);
        case (code)
            3'b100:  return 4'd7;
            3'b110:  return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic rx_cfg_t decode_mode(input logic [7:0] mode, input logic dinv);
        rx_cfg_t c;
        c.nbits    = decode_len(mode[2:0]);
        c.two_stop = mode[4];
        c.par_even = mode[5];
        c.par_en   = mode[6];
        c.sleep    = mode[7];
        c.data_inv = dinv;
        return c;
    endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic line_inv,
    output logic line_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } front_s;

    front_s front_d, front_q;

    always_comb begin
        front_d = front_q;
        if (SYNC_STAGES > 1) begin
            front_d.chain = {front_q.chain[SYNC_STAGES-2:0], rxd ^ line_inv};
        end else begin
            front_d.chain = SYNC_STAGES'(rxd ^ line_inv);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '1;
        else        front_q <= front_d;
    end

    assign line_o = front_q.chain[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                line_i,
    input  logic [7:0]          mode,
    input  logic                data_inv,
    output logic                done_o,
    output logic [DATA_MAX-1:0] shreg_o,
    output logic                par_o,
    output logic                ferr_o,
    output rx_cfg_t             cfg_o
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [CW-1:0]       cnt;
        logic [3:0]          bitn;
        logic [DATA_MAX-1:0] sh;
        logic                par;
        logic                ferr;
        logic                prev;
        rx_cfg_t             cfg;
        logic                done;
    } core_s;

    core_s core_d, core_q;

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (os_tick) begin
            case (core_q.st)
                ST_IDLE: begin
                    core_d.prev = line_i;
                    if (core_q.prev && !line_i) begin
                        core_d.st   = ST_START;
                        core_d.cnt  = '0;
                        core_d.bitn = '0;
                        core_d.sh   = '0;
                        core_d.par  = 1'b0;
                        core_d.ferr = 1'b0;
                        core_d.cfg  = decode_mode(mode, data_inv);
                    end
                end
                ST_START: begin
                    if (core_q.cnt == MID_C) begin
                        core_d.cnt = '0;
                        if (!line_i) begin
                            core_d.st = ST_DATA;
                        end else begin
                            core_d.st   = ST_IDLE;
                            core_d.prev = line_i;
                        end
                    end else begin
                        core_d.cnt = core_q.cnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    if (core_q.cnt == LAST_C) begin
                        core_d.cnt  = '0;
                        core_d.sh   = {line_i, core_q.sh[DATA_MAX-1:1]};
                        core_d.bitn = core_q.bitn + 4'd1;
                        if (core_q.bitn == core_q.cfg.nbits - 4'd1) begin
                            core_d.st = core_q.cfg.par_en ? ST_PAR : ST_STOP1;
                        end
                    end else begin
                        core_d.cnt = core_q.cnt + CW'(1);
                    end
                end
                ST_PAR: begin
                    if (core_q.cnt == LAST_C) begin
                        core_d.cnt = '0;
                        core_d.par = line_i;
                        core_d.st  = ST_STOP1;
                    end else begin
                        core_d.cnt = core_q.cnt + CW'(1);
                    end
                end
                ST_STOP1: begin
                    if (core_q.cnt == LAST_C) begin
                        core_d.cnt  = '0;
                        core_d.ferr = !line_i;
                        if (core_q.cfg.two_stop) begin
                            core_d.st = ST_STOP2;
                        end else begin
                            core_d.st   = ST_IDLE;
                            core_d.done = 1'b1;
                            core_d.prev = line_i;
                        end
                    end else begin
                        core_d.cnt = core_q.cnt + CW'(1);
                    end
                end
                ST_STOP2: begin
                    if (core_q.cnt == LAST_C) begin
                        core_d.cnt  = '0;
                        core_d.ferr = core_q.ferr | !line_i;
                        core_d.st   = ST_IDLE;
                        core_d.done = 1'b1;
                        core_d.prev = line_i;
                    end else begin
                        core_d.cnt = core_q.cnt + CW'(1);
                    end
                end
                default: core_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.st   <= ST_IDLE;
            core_q.prev <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign done_o  = core_q.done;
    assign shreg_o = core_q.sh;
    assign par_o   = core_q.par;
    assign ferr_o  = core_q.ferr;
    assign cfg_o   = core_q.cfg;

    // R4: the second stop phase is entered only when two stop bits were latched
    p_stop2_only_if_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.st == ST_STOP2 |-> core_q.cfg.two_stop);

    // R3: the parity phase is entered only with parity enabled
    p_par_only_if_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.st == ST_PAR |-> core_q.cfg.par_en);

    // R9: a start is never abandoned into the data phase while the line reads high at mid-bit
    p_start_confirm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_START && os_tick && core_q.cnt == MID_C && line_i) |=> core_q.st == ST_IDLE);

endmodule

// File: rtl/uart_rx_post.sv
module uart_rx_post
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic [DATA_MAX-1:0] shreg_i,
    input  logic                par_i,
    input  logic                ferr_i,
    input  rx_cfg_t             cfg_i,
    output logic                valid_o,
    output logic [DATA_MAX-1:0] data_o,
    output logic                perr_o,
    output logic                ferr_o
);
    typedef struct packed {
        logic                valid;
        logic [DATA_MAX-1:0] data;
        logic                perr;
        logic                ferr;
    } post_s;

    post_s post_d, post_q;

    logic [DATA_MAX-1:0] aligned;
    logic [DATA_MAX-1:0] len_mask;
    logic [DATA_MAX-1:0] restored;
    logic                top_bit;
    logic                par_bad;
    logic                accept;

    always_comb begin
        aligned  = shreg_i >> (4'(DATA_MAX) - cfg_i.nbits);
        len_mask = (DATA_MAX'(1) << cfg_i.nbits) - DATA_MAX'(1);
        restored = aligned ^ (cfg_i.data_inv ? len_mask : '0);
        top_bit  = restored[cfg_i.nbits - 4'd1];
        par_bad  = cfg_i.par_en && ((^restored ^ par_i) == cfg_i.par_even);
        accept   = !cfg_i.sleep || top_bit;

        post_d = '0;
        if (done_i && accept) begin
            post_d.valid = 1'b1;
            post_d.data  = restored;
            post_d.perr  = par_bad;
            post_d.ferr  = ferr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) post_q <= '0;
        else        post_q <= post_d;
    end

    assign valid_o = post_q.valid;
    assign data_o  = post_q.data;
    assign perr_o  = post_q.perr;
    assign ferr_o  = post_q.ferr;

    // R8: strobe lasts one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: data and flags are quiet outside the strobe
    p_quiet_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (data_o == '0 && !perr_o && !ferr_o));

    // R7: a non-address character while asleep yields no strobe
    p_sleep_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cfg_i.sleep && !top_bit) |=> !valid_o);

    // R3: parity flag never raised when parity is off
    p_no_parity_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cfg_i.par_en) |=> !perr_o);

    // R2: seven-bit characters leave the upper bits clear
    p_len7_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cfg_i.nbits == 4'd7) |=> data_o[8:7] == 2'b00);

endmodule

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [7:0] mode,
    input  logic       line_inv,
    input  logic       data_inv,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       parity_err,
    output logic       frame_err
);
    logic                line_s;
    logic                done_w;
    logic [DATA_MAX-1:0] shreg_w;
    logic                par_w;
    logic                ferr_w;
    rx_cfg_t             cfg_w;

    uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .line_inv (line_inv),
        .line_o   (line_s)
    );

    uart_rx_core #(.OSR(OSR)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .line_i   (line_s),
        .mode     (mode),
        .data_inv (data_inv),
        .done_o   (done_w),
        .shreg_o  (shreg_w),
        .par_o    (par_w),
        .ferr_o   (ferr_w),
        .cfg_o    (cfg_w)
    );

    uart_rx_post post_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done_w),
        .shreg_i (shreg_w),
        .par_i   (par_w),
        .ferr_i  (ferr_w),
        .cfg_i   (cfg_w),
        .valid_o (rx_valid),
        .data_o  (rx_data),
        .perr_o  (parity_err),
        .ferr_o  (frame_err)
    );

endmodule

// File: tb/uart_sleep_rx_tb.sv
module uart_sleep_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BT         = 16;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] mode = 8'h05;
    logic       line_inv = 1'b0;
    logic       data_inv = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       frame_err;

    int   vectors = 0;
    int   errors  = 0;
    bit   finished = 0;
    int   total_valid = 0;
    logic [10:0] cap [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_sleep_rx dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .mode(mode),
        .line_inv(line_inv), .data_inv(data_inv), .rx_data(rx_data),
        .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            cap[total_valid % 4] <= {frame_err, parity_err, rx_data};
            total_valid <= total_valid + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rxd = v ^ line_inv;
        repeat (BT - 1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rxd = ~line_inv;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mode_word(input int nb, input bit pen, input bit even,
                                             input bit two, input bit slp);
        logic [2:0] code;
        code = (nb == 7) ? 3'b100 : (nb == 8) ? 3'b101 : 3'b110;
        return {slp, pen, even, two, 1'b0, code};
    endfunction

    task automatic send(input logic [8:0] val, input int nb, input bit pen, input bit even,
                        input bit two, input bit flip, input bit s1, input bit s2);
        logic p;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(val[i] ^ data_inv);
        p = ^val;
        if (!even) p = ~p;
        if (pen) drive_bit(p ^ flip);
        drive_bit(s1);
        if (two) drive_bit(s2);
    endtask

    // sends one character, waits, and checks the result at the ports
    task automatic frame_check(input string tag, input logic [8:0] val, input int nb,
                               input bit pen, input bit even, input bit two, input bit slp,
                               input bit flip, input bit s1, input bit s2);
        int base;
        bit deliver;
        logic [10:0] got;
        base = total_valid;
        @(negedge clk);
        mode = mode_word(nb, pen, even, two, slp);
        send(val, nb, pen, even, two, flip, s1, s2);
        idle(24);
        deliver = !slp || val[nb-1];
        chk({tag, " R7 R8 strobe count"}, total_valid - base, deliver ? 1 : 0);
        if (deliver && total_valid > base) begin
            got = cap[base % 4];
            chk({tag, " R2 data"}, int'(got[8:0]), int'(val));
            chk({tag, " R3 parity_err"}, int'(got[9]), int'(pen && flip));
            chk({tag, " R4 frame_err"}, int'(got[10]), int'(!s1 || (two && !s2)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 rx_data", int'(rx_data), 0);
        chk("R1 flags", int'({parity_err, frame_err}), 0);
        rst_n = 1'b1;
        idle(8);

        // full sweep: length, parity mode, stop count, sleep, both inversions
        for (int li = 0; li < 2; li++)
        for (int di = 0; di < 2; di++)
        for (int sl = 0; sl < 2; sl++)
        for (int st = 0; st < 2; st++)
        for (int pm = 0; pm < 3; pm++)
        for (int ln = 0; ln < 3; ln++)
        for (int k = 0; k < 3; k++) begin
            int nb;
            logic [8:0] v;
            string tag;
            nb = 7 + ln;
            v = 9'((k * 299 + ln * 37 + pm * 11 + st * 5 + sl * 71 + di * 13 + li * 101 + 90)
                   & ((1 << nb) - 1));
            if (k == 0) v[nb-1] = 1'b0;
            if (k == 1) v[nb-1] = 1'b1;
            tag = li ? "R5" : (di ? "R6" : "R2");
            @(negedge clk);
            line_inv = li[0];
            rxd = ~line_inv;
            data_inv = di[0];
            idle(4);
            frame_check(tag, v, nb, pm != 0, pm == 2, st[0], sl[0], 1'b0, 1'b1, 1'b1);
        end

        @(negedge clk);
        line_inv = 1'b0; data_inv = 1'b0; rxd = 1'b1;
        idle(4);
        // R3: parity mismatch, odd and even
        frame_check("R3 even flip", 9'h0A5, 8, 1, 1, 0, 0, 1, 1, 1);
        frame_check("R3 odd flip",  9'h13C, 9, 1, 0, 0, 0, 1, 1, 1);
        // R4: each of two stop bits checked
        frame_check("R4 stop1 low", 9'h03C, 7, 0, 0, 1, 0, 0, 0, 1);
        frame_check("R4 stop2 low", 9'h03C, 7, 0, 0, 1, 0, 0, 1, 0);
        frame_check("R4 one stop low", 9'h0F0, 8, 1, 1, 0, 0, 0, 0, 1);
        // R7: errored non-address character dropped while asleep
        frame_check("R7 drop err", 9'h012, 8, 1, 1, 1, 1, 1, 0, 0);
        frame_check("R7 addr err", 9'h192, 9, 1, 0, 0, 1, 1, 1, 1);

        // R9: short glitch rejected
        begin
            int base;
            base = total_valid;
            @(negedge clk); rxd = 1'b0;
            repeat (4) @(negedge clk);
            rxd = 1'b1;
            idle(40);
            chk("R9 glitch strobe count", total_valid - base, 0);
        end

        // R10: back-to-back characters with two stop bits and no gap
        begin
            int base;
            base = total_valid;
            @(negedge clk);
            mode = mode_word(8, 1, 0, 1, 0);
            send(9'h0C3, 8, 1, 0, 1, 0, 1, 1);
            send(9'h05A, 8, 1, 0, 1, 0, 1, 1);
            idle(24);
            chk("R10 strobe count", total_valid - base, 2);
            chk("R10 first data", int'(cap[base % 4][8:0]), 'h0C3);
            chk("R10 second data", int'(cap[(base + 1) % 4][8:0]), 'h05A);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule